// File: doc/BRIEF.md
# Ultra DMA Data-Out Word Receiver

This block sits on the device side of a 16-bit parallel disk interface. It takes in the words that a host writes during an Ultra DMA data-out burst. The host moves a strobe line and the block captures one word from the data bus on every change of that strobe, whether the strobe rises or falls. The captured words go into a small internal FIFO. The FIFO drains to a word stream that uses valid/ready handshaking toward the rest of the device.

The host's STOP line frames each burst. While STOP is asserted the block stays idle and ignores any strobe activity. When the host negates STOP a new burst begins. Asserting STOP again ends the burst. To pause, the host simply holds the strobe at its present level. The block drives a ready flag back to the host so that the host stops strobing before the FIFO runs out of room. If a word still arrives when the FIFO is full, that word is dropped and a sticky overflow flag is raised. A per-burst word counter reports how many words were accepted.

The strobe and STOP inputs are asynchronous to the system clock. Both pass through two-stage synchronisers before any logic uses them.

Top module: `udma_out_rx`

## Requirements
- R1: After reset, word_valid, burst_active, overflow and word_count are 0, and dev_ready is 1.
- R2: burst_active goes to 1 a few clock cycles after stop_in is driven low (STOP negated). It returns to 0 a few cycles after stop_in is driven high (STOP asserted).
- R3: During a burst, every level change of strobe_in captures exactly one word from data_in. Rising and falling changes both capture. Words leave in the order they were captured.
- R4: While strobe_in holds its level, no word is captured and word_count does not change, even over a long pause.
- R5: Strobe changes while STOP is asserted (stop_in high) capture nothing and leave word_count unchanged.
- R6: word_count counts the words accepted into the FIFO during the current burst. It clears to 0 when the next burst starts and keeps its value after the burst ends.
- R7: dev_ready is 0 exactly when the FIFO has MARGIN (2) or fewer free entries, out of DEPTH (8).
- R8: A strobe change during a burst while the FIFO holds DEPTH words drops that word and sets overflow. overflow stays set until the next burst starts, and then it clears.
- R9: word_valid is 1 whenever the FIFO holds a word. word_data stays stable while word_valid is 1 and word_ready is 0. A word is removed on a cycle where word_valid and word_ready are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_in | input | 1 | Host data strobe (asynchronous); each level change carries one word |
| stop_in | input | 1 | Host STOP line (asynchronous); high = asserted |
| data_in | input | 16 | Host data bus |
| word_data | output | 16 | Oldest buffered word |
| word_valid | output | 1 | A word is available on word_data |
| word_ready | input | 1 | Consumer accepts word_data this cycle |
| dev_ready | output | 1 | Device can take more words from the host |
| burst_active | output | 1 | A burst is in progress |
| word_count | output | 16 | Words accepted in the current or most recent burst |
| overflow | output | 1 | A word was dropped because the FIFO was full |

## Verification
The hardest case to reach is a strobe change that arrives while the FIFO already holds all DEPTH words. A well-behaved host would have stopped once dev_ready fell. To get there, the stimulus keeps word_ready low and ignores dev_ready. It strobes ten words into one burst, which fills the FIFO and then pushes two more words past full. It then checks that the count stops at DEPTH, that the overflow flag survives the end of the burst, and that the flag clears when the next burst starts. Random bursts with random pauses, random data and random consumer back-pressure, mixed with strobe toggles while STOP is asserted, cover ordering and the cases where input must be ignored.

// File: rtl/udma_rx_pkg.sv
package udma_rx_pkg;
    parameter int unsigned WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/udma_rx_sync.sv
// Two-flop synchroniser for a vector of independent asynchronous bits.
module udma_rx_sync #(
    parameter int unsigned       WIDTH     = 1,
    parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.s1 <= RESET_VAL;
            sync_q.s2 <= RESET_VAL;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.s2;
endmodule

// File: rtl/udma_rx_fifo.sv
// Word FIFO with an occupancy count; any depth of 2 or more.
module udma_rx_fifo
    import udma_rx_pkg::*;
#(
    parameter  int unsigned DEPTH = 8,
    localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  word_t         wr_data,
    input  logic          pop,
    output word_t         rd_data,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);
    localparam int unsigned   AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] level;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    word_t mem_q [DEPTH];
    logic  do_push, do_pop;

    always_comb begin
        fifo_d  = fifo_q;
        do_push = push && (fifo_q.level != DEPTH_L);
        do_pop  = pop && (fifo_q.level != '0);
        if (do_push) fifo_d.wp = (fifo_q.wp == LAST) ? '0 : fifo_q.wp + 1'b1;
        if (do_pop)  fifo_d.rp = (fifo_q.rp == LAST) ? '0 : fifo_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   fifo_d.level = fifo_q.level + 1'b1;
            2'b01:   fifo_d.level = fifo_q.level - 1'b1;
            default: fifo_d.level = fifo_q.level;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_q <= fifo_t'('0);
        else        fifo_q <= fifo_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[fifo_q.wp] <= wr_data;
    end

    assign rd_data = mem_q[fifo_q.rp];
    assign empty   = (fifo_q.level == '0);
    assign full    = (fifo_q.level == DEPTH_L);
    assign level   = fifo_q.level;

    assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_q.level <= DEPTH_L);
    assert_empty_ptrs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_q.level == '0) |-> (fifo_q.wp == fifo_q.rp));
endmodule

// File: rtl/udma_out_rx.sv
// Device-side receiver for host-to-device Ultra DMA bursts.
module udma_out_rx
    import udma_rx_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned MARGIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_in,
    input  logic              stop_in,
    input  logic [WORD_W-1:0] data_in,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    input  logic              word_ready,
    output logic              dev_ready,
    output logic              burst_active,
    output logic [CNT_W-1:0]  word_count,
    output logic              overflow
);
    localparam int unsigned   LW       = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] DEPTH_L  = LW'(DEPTH);
    localparam logic [LW-1:0] MARGIN_L = LW'(MARGIN);

    typedef struct packed {
        logic             strb_prev;
        logic             active;
        logic [CNT_W-1:0] count;
        logic             ovf;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic [1:0]    sync_w;
    logic          stop_s, strb_s;
    logic          strb_change, burst_start, capture, push, drop, pop;
    logic          fifo_empty, fifo_full;
    logic [LW-1:0] level;

    // STOP resets to asserted so that no burst is seen during reset.
    udma_rx_sync #(.WIDTH(2), .RESET_VAL(2'b10)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({stop_in, strobe_in}),
        .sync_o  (sync_w)
    );
    assign stop_s = sync_w[1];
    assign strb_s = sync_w[0];

    always_comb begin
        strb_change = strb_s ^ ctl_q.strb_prev;
        burst_start = !ctl_q.active && !stop_s;
        capture     = ctl_q.active && strb_change;
        push        = capture && !fifo_full;
        drop        = capture && fifo_full;

        ctl_d           = ctl_q;
        ctl_d.strb_prev = strb_s;
        ctl_d.active    = !stop_s;
        if (burst_start) begin
            ctl_d.count = '0;
            ctl_d.ovf   = 1'b0;
        end else begin
            if (push) ctl_d.count = ctl_q.count + 1'b1;
            if (drop) ctl_d.ovf   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= ctl_t'('0);
        else        ctl_q <= ctl_d;
    end

    udma_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .wr_data (data_in),
        .pop     (pop),
        .rd_data (word_data),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .level   (level)
    );

    assign word_valid   = !fifo_empty;
    assign pop          = word_valid && word_ready;
    assign dev_ready    = (DEPTH_L - level) > MARGIN_L;
    assign burst_active = ctl_q.active;
    assign word_count   = ctl_q.count;
    assign overflow     = ctl_q.ovf;

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));
    assert_count_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_active) |-> (word_count == '0));
    assert_idle_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |=> (burst_active || $stable(word_count)));
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && burst_active) |=> overflow);
    assert_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_ready |-> word_valid);
endmodule

// File: tb/udma_out_rx_tb.sv
`timescale 1ns/1ps
module udma_out_rx_tb;
    localparam int DEPTH  = 8;
    localparam int MARGIN = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        strobe_in, stop_in, word_ready;
    logic [15:0] data_in;
    logic [15:0] word_data;
    logic        word_valid, dev_ready, burst_active, overflow;
    logic [15:0] word_count;

    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;
    logic [15:0] exp_q[$];
    int          m_count;
    bit          m_ovf, m_active;

    always #2.5 clk = ~clk;

    udma_out_rx u_dut (
        .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in), .stop_in(stop_in),
        .data_in(data_in), .word_data(word_data), .word_valid(word_valid),
        .word_ready(word_ready), .dev_ready(dev_ready), .burst_active(burst_active),
        .word_count(word_count), .overflow(overflow)
    );

    function automatic bit exp_ready();
        return (DEPTH - exp_q.size()) > MARGIN;
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_burst();
        stop_in = 1'b0;
        cycles(6);
        m_active = 1'b1; m_count = 0; m_ovf = 1'b0;
        check("R2", "burst_active after STOP negated", burst_active, 1);
        check("R6", "word_count at burst start", word_count, 0);
        check("R8", "overflow cleared at burst start", overflow, 0);
    endtask

    task automatic end_burst();
        stop_in = 1'b1;
        cycles(6);
        m_active = 1'b0;
        check("R2", "burst_active after STOP asserted", burst_active, 0);
        check("R6", "word_count held after burst end", word_count, m_count);
    endtask

    task automatic send_word(logic [15:0] d, int pause);
        data_in = d;
        cycles(2);
        strobe_in = ~strobe_in;
        cycles(6 + pause);
        if (m_active) begin
            if (exp_q.size() < DEPTH) begin
                exp_q.push_back(d);
                m_count++;
            end else begin
                m_ovf = 1'b1;
            end
        end
        check(m_active ? "R3" : "R5", "word_count after strobe change", word_count, m_count);
        check("R8", "overflow", overflow, m_ovf);
        check("R7", "dev_ready", dev_ready, exp_ready());
        check("R9", "word_valid vs occupancy", word_valid, exp_q.size() > 0);
    endtask

    task automatic drain(bit always_ready);
        int guard = 0;
        while (exp_q.size() > 0 && guard < 4000) begin
            @(negedge clk);
            word_ready = always_ready ? 1'b1 : 1'($urandom % 2);
            if (word_ready && word_valid) begin
                check("R9", "word_data in capture order", word_data, exp_q[0]);
                void'(exp_q.pop_front());
            end
            guard++;
        end
        @(negedge clk);
        word_ready = 1'b0;
        cycles(2);
        check("R9", "word_valid after drain", word_valid, 0);
        check("R7", "dev_ready after drain", dev_ready, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; stop_in = 1'b1; strobe_in = 1'b0; data_in = '0; word_ready = 1'b0;
        m_count = 0; m_ovf = 1'b0; m_active = 1'b0;
        cycles(5);
        rst_n = 1'b1;
        cycles(4);
        check("R1", "word_valid after reset", word_valid, 0);
        check("R1", "word_count after reset", word_count, 0);
        check("R1", "overflow after reset", overflow, 0);
        check("R1", "dev_ready after reset", dev_ready, 1);
        check("R1", "burst_active after reset", burst_active, 0);

        // R5: strobe activity while STOP is asserted
        for (int i = 0; i < 3; i++) send_word(16'hDEAD + 16'(i), 0);

        // R3: both edge polarities, then R4: long pause
        start_burst();
        send_word(16'h1234, 0);
        send_word(16'hABCD, 0);
        send_word(16'h0F0F, 0);
        cycles(40);
        check("R4", "word_count unchanged during pause", word_count, 3);
        check("R4", "word_valid during pause", word_valid, 1);
        send_word(16'h5555, 3);
        end_burst();
        send_word(16'hBEEF, 0);  // R5: ignored after the burst
        drain(1'b0);

        // R8: overrun the FIFO with the consumer stalled
        start_burst();
        for (int i = 0; i < DEPTH + 2; i++) send_word(16'hA000 + 16'(i), 0);
        check("R8", "word_count stops at depth", word_count, DEPTH);
        end_burst();
        check("R8", "overflow kept after burst end", overflow, 1);
        drain(1'b1);
        start_burst();
        send_word(16'h7777, 0);
        end_burst();
        drain(1'b0);

        // Random bursts with random pauses and back-pressure
        for (int b = 0; b < 6; b++) begin
            int n = 1 + int'($urandom % 6);
            start_burst();
            for (int w = 0; w < n; w++) send_word(16'($urandom), int'($urandom % 10));
            end_burst();
            if ($urandom % 2) send_word(16'($urandom), 0);
            drain(1'b0);
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule